// File: doc/BRIEF.md
# Clock-generator configuration register bank

This block is the software-visible side of an on-chip clock generator. It holds nine 32-bit words on an APB slave port: a control word (bypass, loop reset, power-down controls, loop mode, reference pre-divider), the loop's feedback and output divider settings, a fractional setting, two spread-spectrum settings, and four 10-bit divider values for the SoC, peripheral, fabric and reference clock domains. Every field is brought out as a plain port so the clock-generation logic can consume it directly. One status bit, the loop lock indication, comes in from outside and shows up in the control word.

Bus accesses pass through a three-state sequencer (idle, read, write). An access phase (select and enable both high) seen at a bus-clock edge moves the sequencer into read or write mode. The transfer completes during the next cycle, with ready driven high, and the sequencer then falls back to idle. Because of this, each transfer takes one wait cycle: ready is low in the first access cycle, and the requester must hold address, direction and write data until it sees ready. The error response is never used. The configuration outputs are plain level signals with no handshake. They change only at the edge that ends a write.

Top module: `cgen_regbank`

## Requirements
- R1: With `presetn` low, the words read back as follows. Word 0 (control) reads 0x03000103, with bit 31 following `lock_in`. Word 1 reads 0x00A00004. Word 8 (reference divider) reads 0x028. Words 2 to 7 read zero.
- R2: An edge with `psel` and `penable` both high, while idle, makes `pready` high for exactly the following cycle, after which the block returns to idle. `pready` stays low in the setup cycle, in the first access cycle, and in any cycle where only one of `psel` and `penable` was high.
- R3: A write updates the addressed word at the edge that ends its ready cycle. The configuration ports show the new value from then on.
- R4: A read returns the addressed word on `prdata` during its ready cycle.
- R5: The control word fields, by bit position, are: bit 0 bypass, bit 1 loop reset, bits 13:8 reference pre-divider, bits 17:16 mode (0 normal, 1 fractional, 2 spread, 3 reserved), bit 24 power-down, bit 25 divider power-down. Bit 31 reads `lock_in`, and writes to bit 31 are ignored.
- R6: Only the assigned bits are stored, and all other bits read zero. Word 1 keeps bits 26:16 (feedback) and 2:0 (output). Words 2 and 4 keep bits 23:0. Word 3 keeps bits 10:0. Words 5 to 8 keep bits 9:0.
- R7: Word n sits at byte offset 4·n (0x00 to 0x20). A read of an offset above 0x20, or of an address that is not word aligned, returns zero. A write to such an address changes nothing.
- R8: `pslverr` is low in every transfer.
- R9: Words 5, 6, 7 and 8 drive `soc_div`, `per_div`, `fab_div` and `ref_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low bus reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while pready is high on a read |
| pready | output | 1 | Transfer completes this cycle |
| pslverr | output | 1 | Error response, always low |
| lock_in | input | 1 | Loop lock status from the clock generator |
| cfg_bypass | output | 1 | Control bit 0 |
| cfg_loop_rst | output | 1 | Control bit 1 |
| cfg_ref_pdiv | output | 6 | Control bits 13:8 |
| cfg_mode | output | 2 | Control bits 17:16 |
| cfg_pdown | output | 1 | Control bit 24 |
| cfg_div_pdown | output | 1 | Control bit 25 |
| cfg_fb_div | output | 11 | Word 1 bits 26:16 |
| cfg_out_div | output | 3 | Word 1 bits 2:0 |
| cfg_frac | output | 24 | Word 2 |
| cfg_spr_rate | output | 11 | Word 3 |
| cfg_spr_step | output | 24 | Word 4 |
| soc_div | output | 10 | Word 5 |
| per_div | output | 10 | Word 6 |
| fab_div | output | 10 | Word 7 |
| ref_div | output | 10 | Word 8 |

## Verification
Two events can land in the same cycle: the ready cycle of a control-word read, and a change of the external lock input. The bench provokes this by flipping `lock_in` just after the edge that moves the sequencer into read mode. It expects bit 31 of that same read to carry the new level, while the stored bits keep their value. A second overlap is a write of all ones to the control word: the stored fields take the ones while bit 31 keeps following the lock input. A scoreboard queue holds the expected read data, and a monitor compares it against the data seen in each ready cycle.

// File: rtl/cgen_pkg.sv
package cgen_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } sq_state_e;

  localparam int WORD_W   = 32;
  localparam int NUM_WORDS = 9;
  localparam int LOCK_POS = 31;

  localparam int IX_CTL  = 0;
  localparam int IX_DIV  = 1;
  localparam int IX_FRAC = 2;
  localparam int IX_SPR1 = 3;
  localparam int IX_SPR2 = 4;
  localparam int IX_DOM0 = 5;

  localparam logic [WORD_W-1:0] CTL_KEEP  = 32'h0303_3F03;
  localparam logic [WORD_W-1:0] DIV_KEEP  = 32'h07FF_0007;
  localparam logic [WORD_W-1:0] FRAC_KEEP = 32'h00FF_FFFF;
  localparam logic [WORD_W-1:0] SPR1_KEEP = 32'h0000_07FF;
  localparam logic [WORD_W-1:0] SPR2_KEEP = 32'h00FF_FFFF;

  localparam logic [WORD_W-1:0] CTL_INIT = 32'h0300_0103;
  localparam logic [WORD_W-1:0] DIV_INIT = 32'h00A0_0004;

endpackage

// File: rtl/cgen_seq.sv
module cgen_seq
  import cgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic psel,
  input  logic penable,
  input  logic pwrite,
  output logic rd_en,
  output logic wr_en,
  output logic ready
);

  sq_state_e state_q, state_d;

  always_comb begin
    state_d = SQ_IDLE;
    if (state_q == SQ_IDLE && psel && penable)
      state_d = pwrite ? SQ_WRITE : SQ_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign rd_en = (state_q == SQ_READ);
  assign wr_en = (state_q == SQ_WRITE);
  assign ready = rd_en | wr_en;

  assert_ready_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && psel && penable) |=> ready);

  assert_back_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable) |=> !ready);

endmodule

// File: rtl/cgen_store.sv
module cgen_store
  import cgen_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int DOM_W   = 10,
  parameter int NUM_DOM = 4,
  parameter logic [DOM_W-1:0] LAST_DOM_INIT = 10'h028
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              idx,
  input  logic [WORD_W-1:0]             wdata,
  output logic [WORD_W-1:0]             ctl_q,
  output logic [WORD_W-1:0]             div_q,
  output logic [WORD_W-1:0]             frac_q,
  output logic [WORD_W-1:0]             spr1_q,
  output logic [WORD_W-1:0]             spr2_q,
  output logic [NUM_DOM-1:0][DOM_W-1:0] dom_q
);

  localparam int LAST_IX = IX_DOM0 + NUM_DOM - 1;

  logic hit_ctl, hit_div, hit_frac, hit_spr1, hit_spr2;

  assign hit_ctl  = wr_en && (idx == IDX_W'(IX_CTL));
  assign hit_div  = wr_en && (idx == IDX_W'(IX_DIV));
  assign hit_frac = wr_en && (idx == IDX_W'(IX_FRAC));
  assign hit_spr1 = wr_en && (idx == IDX_W'(IX_SPR1));
  assign hit_spr2 = wr_en && (idx == IDX_W'(IX_SPR2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_INIT;
      div_q  <= DIV_INIT;
      frac_q <= '0;
      spr1_q <= '0;
      spr2_q <= '0;
    end else begin
      if (hit_ctl)  ctl_q  <= wdata & CTL_KEEP;
      if (hit_div)  div_q  <= wdata & DIV_KEEP;
      if (hit_frac) frac_q <= wdata & FRAC_KEEP;
      if (hit_spr1) spr1_q <= wdata & SPR1_KEEP;
      if (hit_spr2) spr2_q <= wdata & SPR2_KEEP;
    end
  end

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    localparam logic [DOM_W-1:0] INIT = (g == NUM_DOM - 1) ? LAST_DOM_INIT : '0;
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(IX_DOM0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dom_q[g] <= INIT;
      else if (hit) dom_q[g] <= wdata[DOM_W-1:0];
    end
  end

  assert_oob_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx > IDX_W'(LAST_IX)) |=>
      ($stable(ctl_q) && $stable(div_q) && $stable(frac_q) &&
       $stable(spr1_q) && $stable(spr2_q) && $stable(dom_q)));

  assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctl_q) && $stable(div_q) && $stable(dom_q)));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctl_q & ~CTL_KEEP) == '0 && (div_q & ~DIV_KEEP) == '0 &&
               (spr1_q & ~SPR1_KEEP) == '0));

endmodule

// File: rtl/cgen_rdmux.sv
module cgen_rdmux
  import cgen_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int DOM_W   = 10,
  parameter int NUM_DOM = 4
)(
  input  logic                          rd_en,
  input  logic [IDX_W-1:0]              idx,
  input  logic                          lock,
  input  logic [WORD_W-1:0]             ctl_q,
  input  logic [WORD_W-1:0]             div_q,
  input  logic [WORD_W-1:0]             frac_q,
  input  logic [WORD_W-1:0]             spr1_q,
  input  logic [WORD_W-1:0]             spr2_q,
  input  logic [NUM_DOM-1:0][DOM_W-1:0] dom_q,
  output logic [WORD_W-1:0]             rdata
);

  logic [WORD_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (idx == IDX_W'(IX_CTL)) begin
      sel = ctl_q;
      sel[LOCK_POS] = lock;
    end
    if (idx == IDX_W'(IX_DIV))  sel = div_q;
    if (idx == IDX_W'(IX_FRAC)) sel = frac_q;
    if (idx == IDX_W'(IX_SPR1)) sel = spr1_q;
    if (idx == IDX_W'(IX_SPR2)) sel = spr2_q;
    for (int g = 0; g < NUM_DOM; g++)
      if (idx == IDX_W'(IX_DOM0 + g)) sel = WORD_W'(dom_q[g]);
  end

  assign rdata = rd_en ? sel : '0;

endmodule

// File: rtl/cgen_regbank.sv
module cgen_regbank
  import cgen_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DOM_W  = 10
)(
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              lock_in,
  output logic              cfg_bypass,
  output logic              cfg_loop_rst,
  output logic [5:0]        cfg_ref_pdiv,
  output logic [1:0]        cfg_mode,
  output logic              cfg_pdown,
  output logic              cfg_div_pdown,
  output logic [10:0]       cfg_fb_div,
  output logic [2:0]        cfg_out_div,
  output logic [23:0]       cfg_frac,
  output logic [10:0]       cfg_spr_rate,
  output logic [23:0]       cfg_spr_step,
  output logic [DOM_W-1:0]  soc_div,
  output logic [DOM_W-1:0]  per_div,
  output logic [DOM_W-1:0]  fab_div,
  output logic [DOM_W-1:0]  ref_div
);

  localparam int IDX_W   = ADDR_W - 2;
  localparam int NUM_DOM = 4;

  logic rd_en, wr_en;
  logic [IDX_W-1:0] idx;
  logic [WORD_W-1:0] ctl_q, div_q, frac_q, spr1_q, spr2_q;
  logic [NUM_DOM-1:0][DOM_W-1:0] dom_q;

  // misaligned addresses map to an index beyond the last word
  assign idx = (paddr[1:0] == 2'b00) ? paddr[ADDR_W-1:2] : '1;

  cgen_seq u_seq (
    .clk     (pclk),
    .rst_n   (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .ready   (pready)
  );

  cgen_store #(
    .IDX_W (IDX_W), .DOM_W (DOM_W), .NUM_DOM (NUM_DOM),
    .LAST_DOM_INIT (DOM_W'(10'h028))
  ) u_store (
    .clk    (pclk),
    .rst_n  (presetn),
    .wr_en  (wr_en),
    .idx    (idx),
    .wdata  (pwdata),
    .ctl_q  (ctl_q),
    .div_q  (div_q),
    .frac_q (frac_q),
    .spr1_q (spr1_q),
    .spr2_q (spr2_q),
    .dom_q  (dom_q)
  );

  cgen_rdmux #(.IDX_W (IDX_W), .DOM_W (DOM_W), .NUM_DOM (NUM_DOM)) u_rdmux (
    .rd_en  (rd_en),
    .idx    (idx),
    .lock   (lock_in),
    .ctl_q  (ctl_q),
    .div_q  (div_q),
    .frac_q (frac_q),
    .spr1_q (spr1_q),
    .spr2_q (spr2_q),
    .dom_q  (dom_q),
    .rdata  (prdata)
  );

  assign pslverr = 1'b0;

  assign cfg_bypass    = ctl_q[0];
  assign cfg_loop_rst  = ctl_q[1];
  assign cfg_ref_pdiv  = ctl_q[13:8];
  assign cfg_mode      = ctl_q[17:16];
  assign cfg_pdown     = ctl_q[24];
  assign cfg_div_pdown = ctl_q[25];
  assign cfg_fb_div    = div_q[26:16];
  assign cfg_out_div   = div_q[2:0];
  assign cfg_frac      = frac_q[23:0];
  assign cfg_spr_rate  = spr1_q[10:0];
  assign cfg_spr_step  = spr2_q[23:0];
  assign soc_div       = dom_q[0];
  assign per_div       = dom_q[1];
  assign fab_div       = dom_q[2];
  assign ref_div       = dom_q[3];

  assert_lock_readback_R5: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_en && idx == '0) |-> (prdata[LOCK_POS] == lock_in));

  assert_idle_rdata_zero_R4: assert property (@(posedge pclk) disable iff (!presetn)
    !pready |-> (prdata == '0));

endmodule

// File: tb/cgen_regbank_bench.sv
module cgen_regbank_bench;

  logic        clk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        lock_in = 1'b0;
  logic        cfg_bypass, cfg_loop_rst, cfg_pdown, cfg_div_pdown;
  logic [5:0]  cfg_ref_pdiv;
  logic [1:0]  cfg_mode;
  logic [10:0] cfg_fb_div, cfg_spr_rate;
  logic [2:0]  cfg_out_div;
  logic [23:0] cfg_frac, cfg_spr_step;
  logic [9:0]  soc_div, per_div, fab_div, ref_div;

  int total = 0;
  int bad = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model [0:8];
  logic [31:0] keep  [0:8];

  always #2.5 clk = ~clk;

  cgen_regbank u_cgen_regbank (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .lock_in(lock_in),
    .cfg_bypass(cfg_bypass), .cfg_loop_rst(cfg_loop_rst),
    .cfg_ref_pdiv(cfg_ref_pdiv), .cfg_mode(cfg_mode), .cfg_pdown(cfg_pdown),
    .cfg_div_pdown(cfg_div_pdown), .cfg_fb_div(cfg_fb_div),
    .cfg_out_div(cfg_out_div), .cfg_frac(cfg_frac),
    .cfg_spr_rate(cfg_spr_rate), .cfg_spr_step(cfg_spr_step),
    .soc_div(soc_div), .per_div(per_div), .fab_div(fab_div), .ref_div(ref_div)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [11:0] a);
    logic [31:0] v = '0;
    if (a[1:0] == 2'b00 && a[11:2] <= 10'd8) begin
      v = model[a[11:2]];
      if (a[11:2] == 10'd0) v[31] = lock_in;
    end
    return v;
  endfunction

  // monitor: compare read data in each read ready cycle
  initial begin
    forever begin
      @(negedge clk);
      if (presetn && pready && !pwrite) begin
        if (exp_q.size() == 0) begin
          chk("R4 unexpected read completion", prdata, 32'h0);
          bad++;
        end else begin
          chk(tag_q.pop_front(), prdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1 penable = 1;
    #1 chk("R2 ready low in first access cycle", 32'(pready), 32'h0);
    @(posedge clk); #1 chk("R2 ready in completion cycle", 32'(pready), 32'h1);
    chk("R8 no error on write", 32'(pslverr), 32'h0);
    @(posedge clk); #1 psel = 0; penable = 0;
    if (a[1:0] == 2'b00 && a[11:2] <= 10'd8) model[a[11:2]] = d & keep[a[11:2]];
    chk("R2 back to idle after write", 32'(pready), 32'h0);
  endtask

  task automatic apb_rd(input logic [11:0] a, input string tag, input int new_lock);
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1;
    if (new_lock >= 0) lock_in = new_lock[0];
    exp_q.push_back(expect_word(a));
    tag_q.push_back(tag);
    chk("R8 no error on read", 32'(pslverr), 32'h0);
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 9; i++) apb_rd(12'(i * 4), tag, -1);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    keep[0] = 32'h0303_3F03; keep[1] = 32'h07FF_0007; keep[2] = 32'h00FF_FFFF;
    keep[3] = 32'h0000_07FF; keep[4] = 32'h00FF_FFFF;
    for (int i = 5; i < 9; i++) keep[i] = 32'h0000_03FF;
    model[0] = 32'h0300_0103; model[1] = 32'h00A0_0004;
    for (int i = 2; i < 8; i++) model[i] = '0;
    model[8] = 32'h0000_0028;

    repeat (3) @(posedge clk);
    #1 presetn = 1;

    // R1 reset state at the ports and through reads
    chk("R1 bypass after reset", 32'(cfg_bypass), 32'h1);
    chk("R1 loop reset after reset", 32'(cfg_loop_rst), 32'h1);
    chk("R1 feedback divider after reset", 32'(cfg_fb_div), 32'h0A0);
    chk("R1 output divider after reset", 32'(cfg_out_div), 32'h4);
    chk("R9 reference divider after reset", 32'(ref_div), 32'h028);
    chk("R1 idle ready after reset", 32'(pready), 32'h0);
    read_all("R1 reset word readback");

    // R2 lone setup / lone enable starts nothing
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = 1; paddr = 12'h014; pwdata = 32'h3FF;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 chk("R2 setup only gives no ready", 32'(pready), 32'h0);
    end
    psel = 0; penable = 1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 chk("R2 enable only gives no ready", 32'(pready), 32'h0);
    end
    penable = 0;
    chk("R2 no write from partial cycles", 32'(soc_div), 32'h0);

    // R5 control fields
    apb_wr(12'h000, 32'h0002_2A00);
    chk("R5 mode field", 32'(cfg_mode), 32'h2);
    chk("R5 pre-divider field", 32'(cfg_ref_pdiv), 32'h2A);
    chk("R5 bypass cleared", 32'(cfg_bypass), 32'h0);
    chk("R5 power-down cleared", 32'(cfg_pdown), 32'h0);
    apb_wr(12'h000, 32'h0200_0002);
    chk("R5 divider power-down", 32'(cfg_div_pdown), 32'h1);
    chk("R5 loop reset set", 32'(cfg_loop_rst), 32'h1);

    // R6 all-ones writes: reserved bits dropped, lock bit ignored
    for (int i = 0; i < 9; i++) apb_wr(12'(i * 4), 32'hFFFF_FFFF);
    read_all("R6 masked readback");
    chk("R3 fractional port", 32'(cfg_frac), 32'h00FF_FFFF);
    chk("R3 spread rate port", 32'(cfg_spr_rate), 32'h7FF);

    // R5 lock changes in the same cycle the control read completes
    apb_rd(12'h000, "R5 lock flips during read", 1);
    apb_rd(12'h000, "R5 lock falls during read", 0);

    // R9 and R3 distinct domain values, back-to-back write/read
    apb_wr(12'h014, 32'hABCD_0123);
    apb_rd(12'h014, "R3 soc divider readback", -1);
    apb_wr(12'h018, 32'h0000_0256);
    apb_wr(12'h01C, 32'h0000_0001);
    apb_wr(12'h020, 32'h0000_0100);
    chk("R9 soc port", 32'(soc_div), 32'h123);
    chk("R9 peripheral port", 32'(per_div), 32'h256);
    chk("R9 fabric port", 32'(fab_div), 32'h001);
    chk("R9 reference port", 32'(ref_div), 32'h100);
    apb_wr(12'h004, 32'h0123_4565);
    chk("R3 feedback divider port", 32'(cfg_fb_div), 32'h123);
    chk("R3 output divider port", 32'(cfg_out_div), 32'h5);

    // R7 out of range and misaligned
    apb_wr(12'h024, 32'h0000_0000);
    apb_wr(12'hFFC, 32'h0000_0000);
    apb_wr(12'h016, 32'h0000_0000);
    apb_rd(12'h024, "R7 beyond last word reads zero", -1);
    apb_rd(12'h002, "R7 misaligned read zero", -1);
    read_all("R7 words untouched");

    repeat (4) @(posedge clk);
    chk("R4 all reads completed", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule